// File: doc/BRIEF.md
# Register-Mapped GPIO Companion Controller

This block is a small companion controller that sits on a synchronous register bus. It owns sixteen general-purpose lines and a handful of 16-bit control registers. Software sets a direction mask and a level word. The block drives the lines with the level word masked by the direction mask. It also raises a one-cycle strobe on each line whose driven value actually moved. Sixteen input lines can set or clear single bits of the stored level word. These input events do not refresh the driven outputs; the new level reaches the pins only at the next write to the direction or level register.

Only the low six address bits select a register. Write data wider than 16 bits is cut to 16 bits. Reads are registered and appear one cycle after the read enable. An access to an offset that has no register raises a one-cycle error flag. There is no back-pressure anywhere. The bus and the input-event port take a new beat every cycle, so each port has a valid strobe and no ready. A consumer of the change strobe must take it in the one cycle it is shown.

Top module: `gpio_companion`

## Requirements
- R1: A synchronous active-high reset clears every stored register to 0x0000. After reset the driven outputs are all low, no change strobe is high and the error flag is low.
- R2: Only address bits [5:0] select a register; higher address bits have no effect, so 0xFC0 and 0x040 both reach the register at offset 0x00.
- R3: Write data is truncated to its low 16 bits. The registers at offsets 0x00, 0x04, 0x10, 0x14, 0x18 and 0x1C read back the last value written, with no side effect.
- R4: A write to the power register (offset 0x0C) with bit 7 set stores the value with bits 15 and 6 also set (for example 0x0080 reads back as 0x80C0). With bit 7 clear the value is stored as written.
- R5: The status register at offset 0x08 always reads 0x0002. Writes to it change nothing and do not raise the error flag.
- R6: A write to offset 0x24 or to offset 0x28 stores the written value ANDed with the current direction register into the level register. Reads of either offset return the level register.
- R7: The direction register (offset 0x20) reads back as written. In the cycle after any write to offset 0x20, 0x24 or 0x28, the output vector equals level AND direction.
- R8: The change strobe is high for exactly one cycle after such a write, only on the bits where the new output vector differs from the previous one. It is zero when the write leaves the outputs unchanged, and zero in every cycle not following such a write.
- R9: An input event with line index n and level v sets bit n of the level register to v. The output vector and the change strobe stay untouched.
- R10: When a bus write to offset 0x24 or 0x28 and an input event arrive in the same cycle, the level register takes the bus value.
- R11: A read or write at an unmapped offset (any offset in bits [5:0] other than the eleven listed) stores nothing, reads back 0x0000, and raises the error flag for the one cycle after the access.
- R12: Read data updates one cycle after a read enable and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Byte address; bits [5:0] decoded |
| bus_wdata | input | 32 | Write data; low 16 bits stored |
| bus_we | input | 1 | Write enable, one beat per cycle |
| bus_re | input | 1 | Read enable, one beat per cycle |
| bus_rdata | output | 16 | Registered read data |
| bad_access | output | 1 | One-cycle pulse after an unmapped access |
| in_valid | input | 1 | Input event strobe |
| in_line | input | 4 | Line index of the input event |
| in_level | input | 1 | New level for the addressed bit |
| out_level | output | 16 | Driven outputs, level AND direction |
| out_change | output | 16 | One-cycle per-line change strobe |

## Verification
The bench targets the mask that a level write applies against the current direction. A design that stored the raw value would show unmasked bits in the level readback and on the outputs. It checks that narrowing the direction after a level write strobes only the lines that dropped, that a repeated write strobes nothing, and that the strobe does not stay high. A design that used absolute levels in place of differences would fail these. Input events that set bits must stay invisible on the outputs until the next direction write. The bench also drives a bus write and an input event into the same cycle, where a wrong priority leaves the event bit set. The power bit-7 side effect, status write protection, address aliasing through the upper bits and the unmapped-offset error pulse are each checked through readback.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  localparam int OFS_W     = 6;
  localparam int REG_W     = 16;
  localparam int NUM_SLOTS = 7;

  localparam logic [REG_W-1:0] STATUS_VALUE = 16'h0002;
  localparam logic [REG_W-1:0] POWER_FORCE  = 16'h8040;
  localparam int               POWER_TRIG   = 7;

  typedef enum logic [3:0] {
    SEL_MODE, SEL_DIV, SEL_STATUS, SEL_POWER, SEL_CLKC,
    SEL_IRAW, SEL_IMASK, SEL_ISTAT, SEL_DIR, SEL_LVL_W,
    SEL_LVL_R, SEL_NONE
  } reg_sel_e;

  // Storage slot i of the control block answers to this selector.
  function automatic reg_sel_e slot_sel(input int i);
    case (i)
      0:       return SEL_MODE;
      1:       return SEL_DIV;
      2:       return SEL_POWER;
      3:       return SEL_CLKC;
      4:       return SEL_IRAW;
      5:       return SEL_IMASK;
      default: return SEL_ISTAT;
    endcase
  endfunction

  localparam int POWER_SLOT = 2;
endpackage

// File: rtl/gpc_decode.sv
module gpc_decode
  import gpc_pkg::*;
(
  input  logic [OFS_W-1:0] ofs,
  output reg_sel_e         sel,
  output logic             mapped
);
  always_comb begin
    case (ofs)
      6'h00:   sel = SEL_MODE;
      6'h04:   sel = SEL_DIV;
      6'h08:   sel = SEL_STATUS;
      6'h0C:   sel = SEL_POWER;
      6'h10:   sel = SEL_CLKC;
      6'h14:   sel = SEL_IRAW;
      6'h18:   sel = SEL_IMASK;
      6'h1C:   sel = SEL_ISTAT;
      6'h20:   sel = SEL_DIR;
      6'h24:   sel = SEL_LVL_W;
      6'h28:   sel = SEL_LVL_R;
      default: sel = SEL_NONE;
    endcase
    mapped = (sel != SEL_NONE);
  end
endmodule

// File: rtl/gpc_ctrl_regs.sv
module gpc_ctrl_regs
  import gpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] slot_q [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [REG_W-1:0] store_val;
    if (i == POWER_SLOT) begin : g_power
      assign store_val = wdata[POWER_TRIG] ? (wdata | POWER_FORCE) : wdata;
    end else begin : g_plain
      assign store_val = wdata;
    end

    always_ff @(posedge clk) begin
      if (rst)
        slot_q[i] <= '0;
      else if (wr && sel == slot_sel(i))
        slot_q[i] <= store_val;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (sel == slot_sel(i)) rdata = slot_q[i];
  end

  // R4: power write with the trigger bit leaves both forced bits set
  p_power_force_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_POWER && wdata[POWER_TRIG]) |=>
      (slot_q[POWER_SLOT][15] && slot_q[POWER_SLOT][6]));

  // R3: a plain slot that is not written keeps its value
  p_mode_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == SEL_MODE) |=> $stable(slot_q[0]));
endmodule

// File: rtl/gpc_gpio.sv
module gpc_gpio #(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_we,
  input  logic             lvl_we,
  input  logic [LINES-1:0] wdata,
  input  logic             ev_valid,
  input  logic [IDX_W-1:0] ev_idx,
  input  logic             ev_level,
  output logic [LINES-1:0] dir_q,
  output logic [LINES-1:0] level_q,
  output logic [LINES-1:0] out_level,
  output logic [LINES-1:0] out_change
);
  logic [LINES-1:0] ev_hit;
  logic [LINES-1:0] dir_nxt, lvl_nxt, eff_nxt;
  logic             refresh;

  for (genvar g = 0; g < LINES; g++) begin : g_hit
    assign ev_hit[g] = ev_valid && (ev_idx == IDX_W'(g));
  end

  assign dir_nxt = dir_we ? wdata : dir_q;
  // Bus write beats an input event on the level register.
  assign lvl_nxt = lvl_we ? (wdata & dir_q)
                          : ((level_q & ~ev_hit) | (ev_hit & {LINES{ev_level}}));
  assign refresh = dir_we || lvl_we;
  assign eff_nxt = lvl_nxt & dir_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q      <= '0;
      level_q    <= '0;
      out_level  <= '0;
      out_change <= '0;
    end else begin
      dir_q   <= dir_nxt;
      level_q <= lvl_nxt;
      if (refresh) begin
        out_level  <= eff_nxt;
        out_change <= eff_nxt ^ out_level;
      end else begin
        out_change <= '0;
      end
    end
  end

  // R8: strobe marks exactly the bits that moved on the outputs
  p_change_diff_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_change == (out_level ^ $past(out_level))));

  // R8: no strobe without a refreshing write
  p_change_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !refresh |=> (out_change == '0));

  // R6: stored level is the written value masked by the prior direction
  p_level_masked_r6: assert property (@(posedge clk) disable iff (rst)
    lvl_we |=> (level_q == ($past(wdata) & $past(dir_q))));

  // R9: an event alone never moves the outputs
  p_event_silent_r9: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !refresh) |=> $stable(out_level));
endmodule

// File: rtl/gpio_companion.sv
module gpio_companion
  import gpc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bad_access,
  input  logic              in_valid,
  input  logic [IDX_W-1:0]  in_line,
  input  logic              in_level,
  output logic [LINES-1:0]  out_level,
  output logic [LINES-1:0]  out_change
);
  reg_sel_e         sel;
  logic             mapped;
  logic [REG_W-1:0] wdata16;
  logic [REG_W-1:0] ctrl_rd;
  logic [REG_W-1:0] rd_mux;
  logic [LINES-1:0] dir_q, level_q;
  logic             gpio_lvl_we;

  assign wdata16     = bus_wdata[REG_W-1:0];
  assign gpio_lvl_we = bus_we && (sel == SEL_LVL_W || sel == SEL_LVL_R);

  gpc_decode u_dec (
    .ofs    (bus_addr[OFS_W-1:0]),
    .sel    (sel),
    .mapped (mapped)
  );

  gpc_ctrl_regs u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wr    (bus_we),
    .sel   (sel),
    .wdata (wdata16),
    .rdata (ctrl_rd)
  );

  gpc_gpio #(.LINES(LINES)) u_gpio (
    .clk        (clk),
    .rst        (rst),
    .dir_we     (bus_we && sel == SEL_DIR),
    .lvl_we     (gpio_lvl_we),
    .wdata      (wdata16[LINES-1:0]),
    .ev_valid   (in_valid),
    .ev_idx     (in_line),
    .ev_level   (in_level),
    .dir_q      (dir_q),
    .level_q    (level_q),
    .out_level  (out_level),
    .out_change (out_change)
  );

  always_comb begin
    case (sel)
      SEL_STATUS:           rd_mux = STATUS_VALUE;
      SEL_DIR:              rd_mux = REG_W'(dir_q);
      SEL_LVL_W, SEL_LVL_R: rd_mux = REG_W'(level_q);
      SEL_NONE:             rd_mux = '0;
      default:              rd_mux = ctrl_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bad_access <= 1'b0;
    end else begin
      if (bus_re) bus_rdata <= rd_mux;
      bad_access <= (bus_we || bus_re) && !mapped;
    end
  end

  // R11: unmapped reads return zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !mapped) |=> (bus_rdata == '0));

  // R5: status offset always reads its fixed value
  p_status_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_re && sel == SEL_STATUS) |=> (bus_rdata == STATUS_VALUE));

  // R12: read data holds without a read
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_companion_test.sv
module gpio_companion_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic        bad_access;
  logic        in_valid = 1'b0;
  logic [3:0]  in_line = '0;
  logic        in_level = 1'b0;
  logic [15:0] out_level;
  logic [15:0] out_change;

  int errors = 0;
  int checks = 0;
  logic [15:0] rd;
  logic        bad;

  always #2 clk = ~clk;

  gpio_companion uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bad_access(bad_access), .in_valid(in_valid), .in_line(in_line),
    .in_level(in_level), .out_level(out_level), .out_change(out_change)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    bad = bad_access;
  endtask

  task automatic bus_read(input logic [11:0] a);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    rd = bus_rdata; bad = bad_access;
  endtask

  task automatic event_in(input logic [3:0] ln, input logic lv);
    @(negedge clk);
    in_line = ln; in_level = lv; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 out_level", out_level, 16'h0);
    check("R1 out_change", out_change, 16'h0);
    check("R1 bad_access", bad_access, 1'b0);
    bus_read(12'h000); check("R1 mode", rd, 16'h0);
    bus_read(12'h00C); check("R1 power", rd, 16'h0);
    bus_read(12'h020); check("R1 dir", rd, 16'h0);
    bus_read(12'h024); check("R1 level", rd, 16'h0);
    bus_read(12'h008); check("R1/R5 status", rd, 16'h0002);
  endtask

  task automatic t_plain;
    bus_write(12'h000, 32'hABCD_1234);
    bus_write(12'h004, 32'h0000_0011);
    bus_write(12'h010, 32'hFFFF_0022);
    bus_write(12'h014, 32'h0000_8033);
    bus_write(12'h018, 32'h1234_0044);
    bus_write(12'h01C, 32'h0000_FFFF);
    bus_read(12'h000); check("R3 mode truncated", rd, 16'h1234);
    bus_read(12'h004); check("R3 divider", rd, 16'h0011);
    bus_read(12'h010); check("R3 clock ctl", rd, 16'h0022);
    bus_read(12'h014); check("R3 irq raw", rd, 16'h8033);
    bus_read(12'h018); check("R3 irq mask", rd, 16'h0044);
    bus_read(12'h01C); check("R3 irq status", rd, 16'hFFFF);
    @(negedge clk);
    check("R12 rdata held", bus_rdata, 16'hFFFF);
  endtask

  task automatic t_power;
    bus_write(12'h00C, 32'h0000_0080);
    bus_read(12'h00C); check("R4 bit7 forces", rd, 16'h80C0);
    bus_write(12'h00C, 32'h0000_FF7F);
    bus_read(12'h00C); check("R4 bit7 clear", rd, 16'hFF7F);
    bus_write(12'h00C, 32'h0001_0123);
    bus_read(12'h00C); check("R4 plain", rd, 16'h0123);
  endtask

  task automatic t_status;
    bus_write(12'h008, 32'h0000_FFFF);
    check("R5 no bad flag", bad, 1'b0);
    bus_read(12'h008); check("R5 status unchanged", rd, 16'h0002);
  endtask

  task automatic t_alias;
    bus_write(12'hFC0, 32'h0000_5555);
    bus_read(12'h000); check("R2 alias write", rd, 16'h5555);
    bus_read(12'h040); check("R2 alias read", rd, 16'h5555);
  endtask

  task automatic t_gpio;
    bus_write(12'h020, 32'h0000_00FF);
    check("R7 out after dir", out_level, 16'h0000);
    check("R8 no change", out_change, 16'h0000);
    bus_write(12'h024, 32'h0000_FFFF);
    check("R7 out masked", out_level, 16'h00FF);
    check("R8 rise strobe", out_change, 16'h00FF);
    @(negedge clk);
    check("R8 strobe one cycle", out_change, 16'h0000);
    bus_read(12'h028); check("R6 level via read ofs", rd, 16'h00FF);
    bus_read(12'h024); check("R6 level via write ofs", rd, 16'h00FF);
    bus_write(12'h020, 32'h0000_0F0F);
    check("R7 out narrowed", out_level, 16'h000F);
    check("R8 narrow strobe", out_change, 16'h00F0);
    bus_read(12'h020); check("R7 dir readback", rd, 16'h0F0F);
    bus_write(12'h028, 32'h0000_0F03);
    check("R6 out via 0x28", out_level, 16'h0F03);
    check("R8 mixed strobe", out_change, 16'h0F0C);
    bus_write(12'h028, 32'h0000_0F03);
    check("R8 repeat no strobe", out_change, 16'h0000);
  endtask

  task automatic t_events;
    event_in(4'd2, 1'b1);
    check("R9 out untouched", out_level, 16'h0F03);
    check("R9 no strobe", out_change, 16'h0000);
    event_in(4'd8, 1'b0);
    bus_read(12'h024); check("R9 level updated", rd, 16'h0E07);
    check("R9 out still old", out_level, 16'h0F03);
    bus_write(12'h020, 32'h0000_0F0F);
    check("R7 refresh after events", out_level, 16'h0E07);
    check("R8 refresh strobe", out_change, 16'h0104);
    event_in(4'd15, 1'b1);
    bus_read(12'h028); check("R9 input bit15", rd, 16'h8E07);
  endtask

  task automatic t_collision;
    @(negedge clk);
    bus_addr = 12'h024; bus_wdata = 32'h0; bus_we = 1'b1;
    in_line = 4'd1; in_level = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; in_valid = 1'b0;
    check("R10 out cleared", out_level, 16'h0000);
    check("R10 strobe", out_change, 16'h0E07);
    bus_read(12'h024); check("R10 bus wins", rd, 16'h0000);
  endtask

  task automatic t_unmapped;
    bus_write(12'h02C, 32'h0000_FFFF);
    check("R11 write flags", bad, 1'b1);
    @(negedge clk);
    check("R11 flag one cycle", bad_access, 1'b0);
    bus_read(12'h030); check("R11 read zero", rd, 16'h0000);
    check("R11 read flags", bad, 1'b1);
    bus_write(12'h001, 32'h0000_AAAA);
    check("R11 unaligned flags", bad, 1'b1);
    check("R11 outputs kept", out_level, 16'h0000);
    bus_read(12'h000); check("R11 mode kept", rd, 16'h5555);
    check("R11 mapped no flag", bad, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_power();
    t_status();
    t_alias();
    t_gpio();
    t_events();
    t_collision();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule